// File: doc/BRIEF.md
# Palette Colour Lookup Table with Sequential Loader

This block holds a 256-entry colour lookup table in which every entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads it through a write-only 32-bit register port that has two registers. The first register selects the entry index. The second accepts colour bytes one at a time. A small sequencer sends successive data writes to red, then green, then blue. After each blue byte it moves to the next entry, so a whole table or part of one can be streamed in a single burst of data writes after one index write.

A separate lookup port lets a scanout engine turn an 8-bit pixel code into its 24-bit colour. A request is accepted on every cycle. The answer appears with a valid flag exactly one clock later. The lookup port has no back-pressure: its ready is implied high, and the requester must take each result in the cycle it is flagged. The register port follows the same rule. `cfg_ready` stays high, and every write or read finishes in the cycle it is presented.

Top module: `pal_dac`

## Requirements
- R1: After reset, entries 0 to 254 hold 0x000000 and entry 255 holds 0xFFFFFF. The index is 0 and the sequencer points at red.
- R2: A full-word write to byte offset 0x00 loads the index from data bits 31:24 and returns the sequencer to red.
- R3: Each full-word write to byte offset 0x04 stores data bits 31:24 into one component of the current entry. The components are taken in the order red, green, blue. On `lk_rgb`, red sits in bits 23:16, green in 15:8 and blue in 7:0.
- R4: A blue write advances the index by one modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R5: A write to any offset other than 0x00 or 0x04 changes neither the table, the index nor the sequencer.
- R6: A write whose byte enables `cfg_be` are not all ones (4'hF) is ignored completely, at either offset.
- R7: A lookup request (`lk_valid` with `lk_index`) produces `lk_rgb_valid` and the entry's colour on `lk_rgb` on the next clock edge.
- R8: When a lookup and a data write hit the same entry in the same cycle, the lookup returns the value that entry held before the write.
- R9: A register read (`cfg_rd_valid`) is answered one clock later with `cfg_rd_resp_valid` high and `cfg_rd_data` equal to zero.
- R10: `cfg_ready` is high in every cycle after reset, so register accesses complete without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register write strobe |
| cfg_ready | output | 1 | Register port ready, always high |
| cfg_addr | input | 8 | Byte offset of the register write |
| cfg_data | input | 32 | Write data; the payload is in bits 31:24 |
| cfg_be | input | 4 | Byte enables; only 4'hF is accepted |
| cfg_rd_valid | input | 1 | Register read strobe |
| cfg_rd_resp_valid | output | 1 | Read response flag, one cycle after the strobe |
| cfg_rd_data | output | 32 | Read response data, always zero |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 8 | Entry to look up |
| lk_rgb_valid | output | 1 | Lookup result valid, one cycle after the request |
| lk_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
Every cycle, the assertions check the sequencer's transitions:
- an index write loads the index and rewinds to red;
- a blue write increments the index with wraparound;
- rejected writes (bad offset or partial enables) leave index and sequencer unchanged;
- at most one component strobe fires;
- lookup and read responses follow their requests by one cycle.

Only the bench scenarios can show the rest:
- the reset contents of all 256 entries;
- which byte ended up in which component;
- that ignored writes left the table itself untouched;
- that a same-cycle collision returns the old colour.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 32,
  parameter int IDX_OFF  = 0,
  parameter int DATA_OFF = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BUS_W/8-1:0]   wr_be,
  input  logic                 rd_valid,
  output logic                 idx_wr,
  output logic                 dat_wr,
  output logic                 rd_resp_valid
);
  localparam int BE_W = BUS_W / 8;

  logic full_word;
  assign full_word = (wr_be == {BE_W{1'b1}});
  assign idx_wr = wr_valid && full_word && (wr_addr == ADDR_W'(IDX_OFF));
  assign dat_wr = wr_valid && full_word && (wr_addr == ADDR_W'(DATA_OFF));

  always_ff @(posedge clk) begin
    if (!rst_n) rd_resp_valid <= 1'b0;
    else        rd_resp_valid <= rd_valid;
  end

  assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);

  assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_wr && dat_wr));
endmodule

// File: rtl/pal_sequencer.sv
module pal_sequencer
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        idx_wr,
  input  logic                        dat_wr,
  input  logic                        rejected_wr,
  input  logic [COMP_W-1:0]           payload,
  output logic [$clog2(ENTRIES)-1:0]  wr_idx,
  output logic [NUM_COMP-1:0]         comp_sel,
  output logic [COMP_W-1:0]           wr_byte
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] idx_q;
  comp_e            comp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      comp_q <= COMP_RED;
    end else if (idx_wr) begin
      idx_q  <= payload[IDX_W-1:0];
      comp_q <= COMP_RED;
    end else if (dat_wr) begin
      case (comp_q)
        COMP_RED:   comp_q <= COMP_GREEN;
        COMP_GREEN: comp_q <= COMP_BLUE;
        COMP_BLUE: begin
          comp_q <= COMP_RED;
          idx_q  <= idx_q + 1'b1;
        end
        default:    comp_q <= COMP_RED;
      endcase
    end
  end

  always_comb begin
    comp_sel = '0;
    if (dat_wr) begin
      case (comp_q)
        COMP_RED:   comp_sel = 3'b001;
        COMP_GREEN: comp_sel = 3'b010;
        COMP_BLUE:  comp_sel = 3'b100;
        default:    comp_sel = '0;
      endcase
    end
  end

  assign wr_idx  = idx_q;
  assign wr_byte = payload;

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(payload[IDX_W-1:0])) && (comp_q == COMP_RED));

  assert_blue_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && comp_q == COMP_BLUE) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (comp_q == COMP_RED));

  assert_ignored_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected_wr && !idx_wr && !dat_wr) |=> $stable(idx_q) && $stable(comp_q));

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    comp_q != 2'd3);
endmodule

// File: rtl/pal_table.sv
module pal_table
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [NUM_COMP-1:0]         comp_sel,
  input  logic [COMP_W-1:0]           wr_byte,
  input  logic                        rd_valid,
  input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
  output logic                        rd_out_valid,
  output logic [NUM_COMP*COMP_W-1:0]  rd_rgb
);
  localparam int ENT_W = NUM_COMP * COMP_W;
  localparam logic [ENT_W-1:0] WHITE = {ENT_W{1'b1}};

  logic [ENT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        mem[e] <= (e == ENTRIES - 1) ? WHITE : '0;
      end
    end else begin
      for (int c = 0; c < NUM_COMP; c++) begin
        if (comp_sel[c]) begin
          mem[wr_idx][(NUM_COMP-c)*COMP_W-1 -: COMP_W] <= wr_byte;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_out_valid <= 1'b0;
      rd_rgb       <= '0;
    end else begin
      rd_out_valid <= rd_valid;
      if (rd_valid) rd_rgb <= mem[rd_idx];
    end
  end

  assert_one_component_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_sel));

  assert_lookup_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_out_valid);

  assert_lookup_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_out_valid);

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(rd_rgb));
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int IDX_OFF  = 0,
  parameter int DATA_OFF = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_valid,
  output logic                        cfg_ready,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [BUS_W-1:0]            cfg_data,
  input  logic [BUS_W/8-1:0]          cfg_be,
  input  logic                        cfg_rd_valid,
  output logic                        cfg_rd_resp_valid,
  output logic [BUS_W-1:0]            cfg_rd_data,
  input  logic                        lk_valid,
  input  logic [$clog2(ENTRIES)-1:0]  lk_index,
  output logic                        lk_rgb_valid,
  output logic [NUM_COMP*COMP_W-1:0]  lk_rgb
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic                 idx_wr, dat_wr, rejected_wr;
  logic [IDX_W-1:0]     wr_idx;
  logic [NUM_COMP-1:0]  comp_sel;
  logic [COMP_W-1:0]    wr_byte;
  logic [COMP_W-1:0]    payload;

  assign cfg_ready   = 1'b1;
  assign cfg_rd_data = '0;
  assign payload     = cfg_data[BUS_W-1 -: COMP_W];
  assign rejected_wr = cfg_valid && !idx_wr && !dat_wr;

  pal_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IDX_OFF(IDX_OFF), .DATA_OFF(DATA_OFF)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(cfg_valid), .wr_addr(cfg_addr), .wr_be(cfg_be),
    .rd_valid(cfg_rd_valid),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .rd_resp_valid(cfg_rd_resp_valid)
  );

  pal_sequencer #(.ENTRIES(ENTRIES), .COMP_W(COMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .rejected_wr(rejected_wr),
    .payload(payload),
    .wr_idx(wr_idx), .comp_sel(comp_sel), .wr_byte(wr_byte)
  );

  pal_table #(.ENTRIES(ENTRIES), .COMP_W(COMP_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_idx(wr_idx), .comp_sel(comp_sel), .wr_byte(wr_byte),
    .rd_valid(lk_valid), .rd_idx(lk_index),
    .rd_out_valid(lk_rgb_valid), .rd_rgb(lk_rgb)
  );

  assert_partial_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_be != '1) |-> (comp_sel == '0));
endmodule

// File: tb/tb_pal_dac.sv
module tb_pal_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic [3:0]  cfg_be = '0;
  logic        cfg_rd_valid = 1'b0;
  logic        cfg_rd_resp_valid;
  logic [31:0] cfg_rd_data;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_index = '0;
  logic        lk_rgb_valid;
  logic [23:0] lk_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] model [256];
  logic [7:0]  m_idx;
  int          m_comp;

  always #5 clk = ~clk;

  pal_dac dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_be(cfg_be),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_resp_valid(cfg_rd_resp_valid),
    .cfg_rd_data(cfg_rd_data),
    .lk_valid(lk_valid), .lk_index(lk_index),
    .lk_rgb_valid(lk_rgb_valid), .lk_rgb(lk_rgb)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    if (be == 4'hF) begin
      if (a == 8'h00) begin
        m_idx = d[31:24];
        m_comp = 0;
      end else if (a == 8'h04) begin
        model[m_idx][(2-m_comp)*8 +: 8] = d[31:24];
        if (m_comp == 2) begin
          m_comp = 0;
          m_idx = m_idx + 8'd1;
        end else begin
          m_comp++;
        end
      end
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d; cfg_be = be;
    @(negedge clk);
    cfg_valid = 1'b0;
    model_wr(a, d, be);
  endtask

  task automatic look(input logic [7:0] i, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_index = i;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_rgb_valid === 1'b1 && lk_rgb === model[i], req,
          {7'd0, lk_rgb_valid, lk_rgb}, {8'h01, model[i]});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 256; e++) model[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
    m_idx = 8'd0; m_comp = 0;
    check(lk_rgb_valid === 1'b0, "R7 idle after reset", {31'd0, lk_rgb_valid}, 32'd0);
    check(cfg_ready === 1'b1, "R10 ready", {31'd0, cfg_ready}, 32'd1);
    for (int e = 0; e < 256; e++) look(8'(e), "R1 reset contents");
    // first data writes after reset go to entry 0, red first
    bus_wr(8'h04, 32'h12000000, 4'hF);
    look(8'd0, "R1 reset index and sequencer");
  endtask

  task automatic t_stream;
    bus_wr(8'h00, 32'h10000000, 4'hF);
    bus_wr(8'h04, 32'hA1FFFFFF, 4'hF);
    bus_wr(8'h04, 32'hB2000000, 4'hF);
    bus_wr(8'h04, 32'hC3123456, 4'hF);
    look(8'h10, "R3 component order");
    check(model[8'h10] == 24'hA1B2C3, "R3 model", {8'd0, model[8'h10]}, 32'h00A1B2C3);
    bus_wr(8'h04, 32'h44000000, 4'hF);
    bus_wr(8'h04, 32'h55000000, 4'hF);
    look(8'h11, "R4 auto increment partial entry");
    check(cfg_ready === 1'b1, "R10 ready during writes", {31'd0, cfg_ready}, 32'd1);
  endtask

  task automatic t_index_rewind;
    bus_wr(8'h00, 32'h20000000, 4'hF);
    bus_wr(8'h04, 32'h77000000, 4'hF);
    bus_wr(8'h00, 32'h20000000, 4'hF);
    bus_wr(8'h04, 32'h88000000, 4'hF);
    look(8'h20, "R2 index write rewinds to red");
  endtask

  task automatic t_wrap;
    bus_wr(8'h00, 32'hFF000000, 4'hF);
    bus_wr(8'h04, 32'h01000000, 4'hF);
    bus_wr(8'h04, 32'h02000000, 4'hF);
    bus_wr(8'h04, 32'h03000000, 4'hF);
    bus_wr(8'h04, 32'h9A000000, 4'hF);
    look(8'hFF, "R4 last entry written");
    look(8'h00, "R4 wrap to entry 0");
  endtask

  task automatic t_bad_offset;
    bus_wr(8'h00, 32'h30000000, 4'hF);
    bus_wr(8'h04, 32'h11000000, 4'hF);
    bus_wr(8'h08, 32'hEE000000, 4'hF);
    bus_wr(8'h01, 32'h31000000, 4'hF);
    bus_wr(8'h0C, 32'hDD000000, 4'hF);
    look(8'h30, "R5 ignored offsets leave entry");
    look(8'h31, "R5 ignored offsets leave other entry");
    bus_wr(8'h04, 32'h22000000, 4'hF);
    look(8'h30, "R5 sequencer not moved");
  endtask

  task automatic t_partial;
    bus_wr(8'h00, 32'h40000000, 4'hF);
    bus_wr(8'h04, 32'h5A000000, 4'b1000);
    bus_wr(8'h00, 32'h41000000, 4'b0111);
    look(8'h40, "R6 partial data write ignored");
    bus_wr(8'h04, 32'h6B000000, 4'hF);
    look(8'h40, "R6 partial index write ignored");
    look(8'h41, "R6 other entry untouched");
  endtask

  task automatic t_collision;
    logic [23:0] old_val;
    bus_wr(8'h00, 32'h50000000, 4'hF);
    old_val = model[8'h50];
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = 8'h04; cfg_data = 32'hC7000000; cfg_be = 4'hF;
    lk_valid = 1'b1; lk_index = 8'h50;
    @(negedge clk);
    cfg_valid = 1'b0; lk_valid = 1'b0;
    check(lk_rgb_valid === 1'b1 && lk_rgb === old_val, "R8 collision old value",
          {8'd0, lk_rgb}, {8'd0, old_val});
    model_wr(8'h04, 32'hC7000000, 4'hF);
    look(8'h50, "R8 new value afterwards");
  endtask

  task automatic t_read;
    @(negedge clk);
    cfg_rd_valid = 1'b1;
    @(negedge clk);
    cfg_rd_valid = 1'b0;
    check(cfg_rd_resp_valid === 1'b1 && cfg_rd_data === 32'd0, "R9 read returns zero",
          cfg_rd_data, 32'd0);
    @(negedge clk);
    check(cfg_rd_resp_valid === 1'b0, "R9 response single cycle",
          {31'd0, cfg_rd_resp_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_index_rewind();
    t_wrap();
    t_bad_offset();
    t_partial();
    t_collision();
    t_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule